// File: doc/BRIEF.md
# DDS Frequency Sweep Serial Controller

This block runs an external direct digital synthesis chip through a three-wire serial link: a serial clock, a data line and an active-low frame strobe. It produces an endless up/down frequency sweep between a low and a high 28-bit tuning word. The synthesis chip has two frequency registers, and the controller writes them in turn. Each update frame loads one register and also selects it as the active output, so the next frequency is always written into the register that is not currently driving the output. The result is a ramp with no glitches.

After reset the controller sends a single-word reset frame. It then moves the tuning word by a fixed step on every register write. The wait after a register-0 frame is short and the wait after a register-1 frame is long, so the sweep rate is set by the long wait. The limits, the step and all three wait lengths can be loaded through a parallel configuration port while the controller waits between frames. A load restarts the sweep.

Top module: `dds_sweep_ctrl`

## Requirements
- R1: While reset is high and right after it, `dds_frame_n` is 1, `dds_sclk` is 1, `dds_sdo` is 0, `busy` is 0 and `frame_done` is 0. The first frame after reset holds exactly one 16-bit word, 0x0100.
- R2: Every later frame holds exactly five 16-bit words: control, low half, high half, the phase word 0xC000, and then the control word again.
- R3: The low half is {tag, tuning[13:0]} and the high half is {tag, tuning[27:14]}. The tag in bits [15:14] is 2'b01 when register 0 is the target and 2'b10 when register 1 is the target.
- R4: The control word is 0x2000 for register 0 and 0x2800 for register 1. Update frames alternate between the two registers, and register 0 comes first after the reset frame and after each configuration load.
- R5: When sweeping up, a register-0 frame carries the working word W and the register-1 frame that follows carries W+step. After a register-1 frame, once the word has advanced to W+2·step, the direction turns to down if that new word is greater than or equal to the high limit.
- R6: When sweeping down, the words fall by the step in the same register-0/register-1 pattern. After a register-1 frame, the direction turns to up if the new word is less than or equal to the low limit.
- R7: Between frames the strobe stays high for at least the short gap after the reset frame or a register-0 frame, and for at least the long gap after a register-1 frame. In both cases it stays high for no more than 6 cycles beyond that gap.
- R8: After the strobe falls, at least word-gap system cycles pass before the first falling edge of the serial clock.
- R9: Words go out MSB first. The data line changes only while the serial clock is high and holds steady while it is low, and the receiver samples on the falling edge. The serial clock is high, and the data line is low, whenever the strobe is high.
- R10: `busy` is high whenever the strobe is low. `frame_done` is a one-cycle pulse in the cycle in which the strobe rises.
- R11: A `cfg_load` pulse taken while the controller waits between frames latches all configuration inputs. It restarts the sweep at the new low limit, going up, with register 0 next. A pulse taken while `busy` is high is ignored.
- R12: Without a load, the sweep uses the low limit 0x29F1, the high limit 0xD167 and a step of 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load pulse for the configuration inputs |
| cfg_low | input | 28 | Low tuning limit |
| cfg_high | input | 28 | High tuning limit |
| cfg_step | input | 28 | Tuning step per register write |
| cfg_short_gap | input | GAP_W | Wait after a reset or register-0 frame, in cycles |
| cfg_long_gap | input | GAP_W | Wait after a register-1 frame, in cycles |
| cfg_word_gap | input | WG_W | Idle cycles before each word in a frame |
| dds_sclk | output | 1 | Serial clock, idles high |
| dds_sdo | output | 1 | Serial data, MSB first |
| dds_frame_n | output | 1 | Active-low frame strobe |
| busy | output | 1 | High while a frame is being sent |
| frame_done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The hardest events to reach from the ports are the turnarounds, because they depend on where the running word lands relative to a limit after a register-1 write. The bench makes them happen through reloads. Some configurations put the high limit exactly two steps above the low limit, so both turnarounds fire with an exact hit. Other, random configurations stop short of a step multiple, so the turn comes after an overshoot. The other hard case is a load that must be ignored. The bench pulses `cfg_load` in the middle of a frame with unrelated values, then checks that later frames still follow the old sweep.

// File: rtl/dds_sweep_pkg.sv
package dds_sweep_pkg;

    localparam int WORD_W = 16;
    localparam int HALF_W = 14;
    localparam int TW_W   = 2 * HALF_W;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int IDX_W  = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [TW_W-1:0]   tw_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic { FR_RESET = 1'b0, FR_UPDATE = 1'b1 } frame_kind_e;

    typedef struct packed {
        frame_kind_e kind;
        logic        sel;   // target frequency register
        tw_t         tw;
    } frame_req_t;

    typedef struct packed {
        tw_t low;
        tw_t high;
        tw_t step;
    } sweep_lim_t;

    typedef enum logic [1:0] { SW_ISSUE, SW_FRAME, SW_WAIT } sweep_state_e;
    typedef enum logic [1:0] { FQ_IDLE, FQ_GAP, FQ_SHIFT } frame_state_e;

    localparam word_t RESET_WORD = 16'h0100;
    localparam word_t PHASE_WORD = 16'hC000;
    localparam word_t CTL_REG0   = 16'h2000;
    localparam word_t CTL_REG1   = 16'h2800;

    function automatic idx_t last_idx(frame_kind_e k);
        return (k == FR_RESET) ? idx_t'(0) : idx_t'(4);
    endfunction

    // Word at position i of the frame described by r.
    function automatic word_t frame_word(frame_req_t r, idx_t i);
        logic [1:0] tag;
        word_t      ctl;
        word_t      w;
        tag = r.sel ? 2'b10 : 2'b01;
        ctl = r.sel ? CTL_REG1 : CTL_REG0;
        if (r.kind == FR_RESET) begin
            w = RESET_WORD;
        end else begin
            case (i)
                3'd0, 3'd4: w = ctl;
                3'd1:       w = {tag, r.tw[HALF_W-1:0]};
                3'd2:       w = {tag, r.tw[TW_W-1:HALF_W]};
                default:    w = PHASE_WORD;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/dds_wait_timer.sv
module dds_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;
    logic         run;

    // A restart in the same cycle wins over expiry.
    assign expired = run && (cnt == '0) && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= len;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dds_word_shifter.sv
module dds_word_shifter
    import dds_sweep_pkg::*;
#(
    parameter int CLK_HALF = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t word,
    output logic  sclk,
    output logic  sdo,
    output logic  done
);
    localparam int              DIV_W    = $clog2(CLK_HALF) + 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HALF - 1);

    word_t            sh;
    logic [BIT_W-1:0] bits_left;
    logic [DIV_W-1:0] div;
    logic             active;

    assign sdo = active & sh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            bits_left <= '0;
            div       <= '0;
            active    <= 1'b0;
            sclk      <= 1'b1;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                sh        <= word;
                bits_left <= BIT_W'(WORD_W - 1);
                div       <= DIV_LAST;
                active    <= 1'b1;
                sclk      <= 1'b1;
            end else if (active) begin
                if (div != '0) begin
                    div <= div - 1'b1;
                end else begin
                    div <= DIV_LAST;
                    if (sclk) begin
                        sclk <= 1'b0;          // receiver samples here
                    end else begin
                        sclk <= 1'b1;          // next bit goes out with the rise
                        if (bits_left == '0) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            sh        <= {sh[WORD_W-2:0], 1'b0};
                            bits_left <= bits_left - 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dds_frame_seq.sv
module dds_frame_seq
    import dds_sweep_pkg::*;
#(
    parameter int CLK_HALF = 4,
    parameter int WG_W     = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  frame_req_t      req,
    input  logic [WG_W-1:0] word_gap,
    output logic            sclk,
    output logic            sdo,
    output logic            frame_n,
    output logic            busy,
    output logic            frame_done
);
    frame_state_e st;
    frame_req_t   req_q;
    idx_t         idx;
    logic         tmr_start, tmr_exp, sh_start, sh_done, last;
    word_t        sh_word;

    assign last      = (idx == last_idx(req_q.kind));
    assign tmr_start = (st == FQ_IDLE && start) || (st == FQ_SHIFT && sh_done && !last);
    assign sh_start  = (st == FQ_GAP) && tmr_exp;
    assign sh_word   = frame_word(req_q, idx);

    dds_wait_timer #(.W(WG_W)) u_gap (
        .clk(clk), .rst(rst), .start(tmr_start), .len(word_gap), .expired(tmr_exp)
    );

    dds_word_shifter #(.CLK_HALF(CLK_HALF)) u_shift (
        .clk(clk), .rst(rst), .start(sh_start), .word(sh_word),
        .sclk(sclk), .sdo(sdo), .done(sh_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= FQ_IDLE;
            req_q      <= '0;
            idx        <= '0;
            frame_n    <= 1'b1;
            busy       <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (st)
                FQ_IDLE: if (start) begin
                    req_q   <= req;
                    idx     <= '0;
                    frame_n <= 1'b0;
                    busy    <= 1'b1;
                    st      <= FQ_GAP;
                end
                FQ_GAP: if (tmr_exp) st <= FQ_SHIFT;
                FQ_SHIFT: if (sh_done) begin
                    if (last) begin
                        frame_n    <= 1'b1;
                        busy       <= 1'b0;
                        frame_done <= 1'b1;
                        st         <= FQ_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= FQ_GAP;
                    end
                end
                default: st <= FQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dds_sweep_ctrl.sv
module dds_sweep_ctrl
    import dds_sweep_pkg::*;
#(
    parameter int          CLK_HALF  = 4,
    parameter int          GAP_W     = 24,
    parameter int          WG_W      = 12,
    parameter logic [27:0] DEF_LOW   = 28'h00029F1,
    parameter logic [27:0] DEF_HIGH  = 28'h000D167,
    parameter logic [27:0] DEF_STEP  = 28'd40,
    parameter int          DEF_SHORT = 1000,
    parameter int          DEF_LONG  = 1000000,
    parameter int          DEF_WGAP  = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [27:0]      cfg_low,
    input  logic [27:0]      cfg_high,
    input  logic [27:0]      cfg_step,
    input  logic [GAP_W-1:0] cfg_short_gap,
    input  logic [GAP_W-1:0] cfg_long_gap,
    input  logic [WG_W-1:0]  cfg_word_gap,
    output logic             dds_sclk,
    output logic             dds_sdo,
    output logic             dds_frame_n,
    output logic             busy,
    output logic             frame_done
);
    sweep_state_e     st;
    sweep_lim_t       lim;
    logic [GAP_W-1:0] short_q, long_q, gap_len;
    logic [WG_W-1:0]  wgap_q;
    tw_t              tw, tw_next;
    logic             rst_pend, sel, down;
    logic             load_ok, gap_start, gap_exp;
    frame_req_t       req;

    assign load_ok   = cfg_load && (st == SW_WAIT);
    assign tw_next   = down ? (tw - lim.step) : (tw + lim.step);
    assign req       = '{kind: (rst_pend ? FR_RESET : FR_UPDATE), sel: sel, tw: tw};
    assign gap_start = load_ok || (st == SW_FRAME && frame_done);
    assign gap_len   = load_ok ? cfg_short_gap : ((rst_pend || !sel) ? short_q : long_q);

    dds_frame_seq #(.CLK_HALF(CLK_HALF), .WG_W(WG_W)) u_seq (
        .clk(clk), .rst(rst), .start(st == SW_ISSUE), .req(req), .word_gap(wgap_q),
        .sclk(dds_sclk), .sdo(dds_sdo), .frame_n(dds_frame_n),
        .busy(busy), .frame_done(frame_done)
    );

    dds_wait_timer #(.W(GAP_W)) u_frame_gap (
        .clk(clk), .rst(rst), .start(gap_start), .len(gap_len), .expired(gap_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SW_ISSUE;
            lim      <= '{low: DEF_LOW, high: DEF_HIGH, step: DEF_STEP};
            short_q  <= GAP_W'(DEF_SHORT);
            long_q   <= GAP_W'(DEF_LONG);
            wgap_q   <= WG_W'(DEF_WGAP);
            tw       <= DEF_LOW;
            rst_pend <= 1'b1;
            sel      <= 1'b0;
            down     <= 1'b0;
        end else begin
            case (st)
                SW_ISSUE: st <= SW_FRAME;
                SW_FRAME: if (frame_done) begin
                    st <= SW_WAIT;
                    if (rst_pend) begin
                        rst_pend <= 1'b0;
                    end else begin
                        tw  <= tw_next;
                        sel <= ~sel;
                        if (sel) begin
                            if (!down && tw_next >= lim.high)     down <= 1'b1;
                            else if (down && tw_next <= lim.low)  down <= 1'b0;
                        end
                    end
                end
                SW_WAIT: begin
                    if (load_ok) begin
                        lim     <= '{low: cfg_low, high: cfg_high, step: cfg_step};
                        short_q <= cfg_short_gap;
                        long_q  <= cfg_long_gap;
                        wgap_q  <= cfg_word_gap;
                        tw      <= cfg_low;
                        sel     <= 1'b0;
                        down    <= 1'b0;
                    end else if (gap_exp) begin
                        st <= SW_ISSUE;
                    end
                end
                default: st <= SW_ISSUE;
            endcase
        end
    end
endmodule

// File: rtl/dds_sweep_ctrl_chk.sv
module dds_sweep_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic dds_sclk,
    input logic dds_sdo,
    input logic dds_frame_n,
    input logic busy,
    input logic frame_done
);
    // R9: lines at rest outside frames
    p_idle_lines_r9: assert property (@(posedge clk) disable iff (rst)
        dds_frame_n |-> (dds_sclk && !dds_sdo));

    // R9: data holds while the serial clock stays low
    p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!dds_sclk && $past(!dds_sclk)) |-> $stable(dds_sdo));

    // R9: strobe edges only with the serial clock high
    p_strobe_edge_r9: assert property (@(posedge clk) disable iff (rst)
        ($fell(dds_frame_n) || $rose(dds_frame_n)) |-> dds_sclk);

    // R10: busy covers the frame
    p_busy_frame_r10: assert property (@(posedge clk) disable iff (rst)
        !dds_frame_n |-> busy);

    // R10: done marks the rising strobe
    p_done_edge_r10: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $rose(dds_frame_n));

    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
endmodule

bind dds_sweep_ctrl dds_sweep_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .dds_sclk(dds_sclk), .dds_sdo(dds_sdo),
    .dds_frame_n(dds_frame_n), .busy(busy), .frame_done(frame_done)
);

// File: tb/dds_sweep_ctrl_tb.sv
module dds_sweep_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int GAP_W      = 24;
    localparam int WG_W       = 12;
    localparam int WD_LIMIT   = 190000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_load = 1'b0;
    logic [27:0]      cfg_low = '0, cfg_high = '0, cfg_step = '0;
    logic [GAP_W-1:0] cfg_short_gap = '0, cfg_long_gap = '0;
    logic [WG_W-1:0]  cfg_word_gap = '0;
    logic             dds_sclk, dds_sdo, dds_frame_n, busy, frame_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_sweep_ctrl #(
        .CLK_HALF(2), .GAP_W(GAP_W), .WG_W(WG_W),
        .DEF_SHORT(20), .DEF_LONG(50), .DEF_WGAP(3)
    ) u_dut (.*);

    int errors = 0, checks = 0, cyc = 0, frames = 0, n_upd = 0;
    bit run_mon = 0, finished = 0;

    // bench model of the sweep
    logic [27:0] m_low = 28'h29F1, m_high = 28'hD167, m_step = 28'd40, m_tw = 28'h29F1;
    int   m_short = 20, m_long = 50, m_wgap = 3;
    bit   m_sel = 0, m_down = 0, m_rst_pend = 1, m_last_long = 0, m_skip_gap = 1;
    string m_tag = "";

    task automatic chk(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(int i, bit s, logic [27:0] t);
        logic [1:0] tag;
        tag = s ? 2'b10 : 2'b01;
        case (i)
            0, 4:    return s ? 16'h2800 : 16'h2000;
            1:       return {tag, t[13:0]};
            2:       return {tag, t[27:14]};
            default: return 16'hC000;
        endcase
    endfunction

    // serial capture
    logic [15:0] fw [0:7];
    logic [15:0] cur = '0;
    int nw = 0, nb = 0, t_fall = 0, t_rise = 0;
    bit first_bit = 0, have_rise = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT && !finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(negedge dds_frame_n) if (run_mon) begin
        nw = 0; nb = 0; first_bit = 1; t_fall = cyc;
        if (have_rise && !m_skip_gap) begin
            int g;
            g = m_last_long ? m_long : m_short;
            chk((cyc - t_rise) >= g && (cyc - t_rise) <= g + 6,
                $sformatf("R7 strobe-high gap (long=%0d)", m_last_long), cyc - t_rise, g);
        end
        m_skip_gap = 0;
    end

    always @(negedge dds_sclk) if (run_mon && !dds_frame_n) begin
        if (first_bit) begin
            first_bit = 0;
            chk((cyc - t_fall) >= m_wgap, "R8 idle before first bit", cyc - t_fall, m_wgap);
        end
        cur = {cur[14:0], dds_sdo};
        nb++;
        if (nb == 16) begin
            if (nw < 8) fw[nw] = cur;
            nw++; nb = 0;
        end
    end

    task automatic check_frame();
        string lab;
        logic [27:0] nt;
        if (m_rst_pend) begin
            chk(nw == 1 && fw[0] == 16'h0100, "R1 reset frame", {nw, fw[0]}, {32'd1, 16'h0100});
            m_rst_pend = 0; m_last_long = 0;
            return;
        end
        lab = (m_tag != "") ? m_tag : (n_upd < 6 ? "R12" : (m_down ? "R6" : "R5"));
        m_tag = "";
        chk(nw == 5, $sformatf("%s R2 word count", lab), nw, 5);
        for (int i = 0; i < 5; i++) begin
            string k;
            k = (i == 0 || i == 4) ? "R4 control" : ((i == 3) ? "R2 phase" : "R3 half");
            chk(fw[i] == exp_word(i, m_sel, m_tw),
                $sformatf("%s %s word%0d reg%0d", lab, k, i, m_sel), fw[i], exp_word(i, m_sel, m_tw));
        end
        nt = m_down ? m_tw - m_step : m_tw + m_step;
        if (m_sel) begin
            if (!m_down && nt >= m_high)     m_down = 1;
            else if (m_down && nt <= m_low)  m_down = 0;
        end
        m_tw = nt;
        m_last_long = m_sel;
        m_sel = ~m_sel;
        n_upd++;
    endtask

    always @(posedge dds_frame_n) if (run_mon) begin
        t_rise = cyc; have_rise = 1;
        check_frame();
        frames++;
    end

    task automatic wait_frames(int n);
        repeat (n) @(posedge dds_frame_n);
    endtask

    task automatic do_load(logic [27:0] l, logic [27:0] h, logic [27:0] s,
                           int sg, int lg, int wg);
        @(posedge dds_frame_n);
        @(negedge clk); @(negedge clk);
        chk(busy == 0, "R10 busy low between frames", busy, 0);
        chk(dds_sclk == 1 && dds_sdo == 0, "R9 idle lines between frames", {dds_sclk, dds_sdo}, 2'b10);
        cfg_low = l; cfg_high = h; cfg_step = s;
        cfg_short_gap = GAP_W'(sg); cfg_long_gap = GAP_W'(lg); cfg_word_gap = WG_W'(wg);
        cfg_load = 1;
        m_low = l; m_high = h; m_step = s; m_tw = l; m_sel = 0; m_down = 0;
        m_short = sg; m_long = lg; m_wgap = wg; m_skip_gap = 1; m_tag = "R11";
        @(negedge clk);
        cfg_load = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        chk(dds_frame_n == 1 && dds_sclk == 1 && dds_sdo == 0 && busy == 0 && frame_done == 0,
            "R1 reset levels", {dds_frame_n, dds_sclk, dds_sdo, busy, frame_done}, 5'b11000);
        run_mon = 1;
        rst = 0;
        // default sweep (R12)
        wait_frames(7);
        // load pulse in the middle of a frame must be ignored (R11)
        @(negedge dds_frame_n);
        @(negedge clk);
        chk(busy == 1, "R10 busy during frame", busy, 1);
        cfg_low = 28'd7; cfg_high = 28'd9; cfg_step = 28'd1;
        cfg_short_gap = 5; cfg_long_gap = 5; cfg_word_gap = 0;
        cfg_load = 1;
        m_tag = "R11";
        @(negedge clk);
        cfg_load = 0;
        wait_frames(3);
        // directed: both turnarounds on exact hits
        do_load(28'd1000, 28'd1000 + 2 * 28'd25, 28'd25, 12, 40, 0);
        wait_frames(12);
        // directed: large word spanning both halves
        do_load(28'h3FF_C000, 28'h400_8000, 28'h2000, 10, 30, 5);
        wait_frames(14);
        // random configurations with overshoot
        for (int c = 0; c < 3; c++) begin
            logic [27:0] s, l, h;
            int k;
            s = 28'(1 + $urandom % 60);
            l = s + 28'($urandom % 5000);
            k = 1 + $urandom % 4;
            h = l + 28'(2 * k) * s - 28'($urandom % s);
            do_load(l, h, s, 8 + $urandom % 20, 30 + $urandom % 60, $urandom % 6);
            wait_frames(24);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule